// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block is a memory-mapped timer with several independent channels sharing one register bus. Each channel owns an up-counter that advances on prescaled ticks of a slow time base. The slow time base comes in as a single-cycle enable pulse, `slow_tick`, in the system clock domain. A channel also has a compare register, a match flag, an overflow flag and a level interrupt output. A shared run register holds one bit per channel, so software starts or freezes any channel without touching the others.

In periodic mode a channel divides the time base into periods of compare+1 ticks. In free-running mode the counter passes the compare value and wraps at all ones, which sets the overflow flag. Software clears a flag by writing zero to it. A counter write takes effect two prescaled ticks after the write, which mirrors a counter that lives in a slow domain. The register port carries no stream data. It accepts a write in every cycle in which `bus_valid` and `bus_write` are both high, and it never applies back-pressure. Read data is combinational from `bus_addr`.

Top module: `cm_timer`

## Requirements
- R1: After reset the run register, every control/status register and every counter read 0, and every compare register reads all ones.
- R2: Bit n of the run register (byte offset 0x00) runs channel n. While the bit is 0 the channel's counter holds its value.
- R3: Channel n occupies byte offset 0x10+n*0x10, with control/status at +0x0, counter at +0x4 and compare at +0x8. Any other offset reads 0 and ignores writes, including +0xC, misaligned addresses and channels at or above NUM_CH.
- R4: Control/status bits 2:0 select the prescaler. The value 7 gives one tick per slow pulse, and 4, 5 and 6 give one tick per 8, 32 and 128 slow pulses. The values 0 to 3 give no ticks.
- R5: With bit 8 set (periodic), a tick taken while the counter equals compare returns the counter to 0, so one period is compare+1 ticks.
- R6: With bit 8 clear, the counter runs past compare, a tick at all ones wraps it to 0, and that wrap sets the overflow flag, bit 14.
- R7: The match flag, bit 15, is set by the tick that makes the counter equal to the compare value, in either mode.
- R8: A control/status write clears bit 15 or bit 14 where the written bit is 0 and leaves it where the written bit is 1. A flag set in the same cycle wins over the clear.
- R9: The channel's irq line is high exactly while bit 15 is 1, bit 7 is 1 and bits 5:4 equal 10. The codes 00 and 01 raise nothing.
- R10: A counter write loads the value on the second prescaled tick after the write. Until then the register reads the running count. A newer write restarts the wait.
- R11: Control/status bits 8, 7, 5:4 and 2:0 read back as written. Bits 31:16, 13:9, 6 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse of the slow time base |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | Access is a write (with bus_valid) |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Level interrupt, one per channel |

## Verification
The timing checks use the bypass prescaler with a pulse in every cycle, and also a sparse pulse pattern with the divide-by-8, divide-by-32 and divide-by-128 settings. These separate a fault in the divider from a fault in the counting path. A periodic channel with a small compare value shows whether the wrap happens at compare or one tick later. A free-running channel loaded close to all ones exercises the overflow wrap and the later match within one run. Flag writes with one bit at zero and the other at one, the 00 and 01 request codes, and accesses to unmapped offsets show that each control bit acts only on its own target. A counter read right after a counter write distinguishes the two-tick delayed load from an immediate one.

// File: rtl/cm_timer_pkg.sv
package cm_timer_pkg;
  localparam int BUS_W     = 32;
  localparam int PRE_W     = 7;
  localparam int MF_BIT    = 15;
  localparam int OVF_BIT   = 14;
  localparam int PER_BIT   = 8;
  localparam int IE_BIT    = 7;
  localparam int REQ_LSB   = 4;
  localparam int CKS_LSB   = 0;
  localparam logic [1:0] REQ_IRQ = 2'b10;

  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_CNT  = 2'd1,
    W_CMP  = 2'd2,
    W_NONE = 2'd3
  } word_e;

  typedef struct packed {
    logic       periodic;
    logic       ie;
    logic [1:0] req;
    logic [2:0] cks;
  } ctrl_t;

  // last prescaler state before a tick, for the dividing codes
  function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] sel);
    case (sel)
      3'd4:    presc_last = PRE_W'(7);
      3'd5:    presc_last = PRE_W'(31);
      3'd6:    presc_last = PRE_W'(127);
      default: presc_last = '0;
    endcase
  endfunction
endpackage

// File: rtl/cm_timer_regdec.sv
module cm_timer_regdec
  import cm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_run,
  output logic [NUM_CH-1:0] ch_hit,
  output word_e             word
);
  localparam int BLK_W = ADDR_W - 4;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  assign is_run  = (addr == '0);
  assign word    = word_e'(addr[3:2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i] = aligned && (addr[ADDR_W-1:4] == BLK_W'(i + 1));
  end
endmodule

// File: rtl/cm_timer_presc.sv
module cm_timer_presc
  import cm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow_tick,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;
  logic             div_on;
  logic             bypass;

  always_comb begin
    last   = presc_last(sel);
    div_on = (sel == 3'd4) || (sel == 3'd5) || (sel == 3'd6);
    bypass = (sel == 3'd7);
    tick   = run && slow_tick && (bypass || (div_on && pre_q == last));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || !div_on) begin
      pre_q <= '0;
    end else if (slow_tick) begin
      pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/cm_timer_chan.sv
module cm_timer_chan
  import cm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              slow_tick,
  input  logic              ctrl_we,
  input  logic              cnt_we,
  input  logic              cmp_we,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  ctrl_rd,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic [CNT_W-1:0]  cmp_rd,
  output logic              tick_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic             mf_q, ovf_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, pend_val_q, cnt_next;
  logic             pend_v_q;
  logic [1:0]       pend_n_q;
  logic             tick, load_now, count_now, hit, wrap;

  cm_timer_presc u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .slow_tick (slow_tick),
    .sel       (ctrl_q.cks),
    .tick      (tick)
  );

  always_comb begin
    load_now  = tick && pend_v_q && (pend_n_q == 2'd1) && !cnt_we;
    count_now = tick && !load_now;
    if (ctrl_q.periodic)
      cnt_next = (cnt_q == cmp_q) ? '0 : cnt_q + 1'b1;
    else
      cnt_next = cnt_q + 1'b1;
    hit  = count_now && (cnt_next == cmp_q);
    wrap = count_now && !ctrl_q.periodic && (&cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      mf_q       <= 1'b0;
      ovf_q      <= 1'b0;
      cnt_q      <= '0;
      cmp_q      <= '1;
      pend_val_q <= '0;
      pend_v_q   <= 1'b0;
      pend_n_q   <= 2'd0;
    end else begin
      if (load_now)       cnt_q <= pend_val_q;
      else if (count_now) cnt_q <= cnt_next;

      if (cnt_we) begin
        pend_v_q   <= 1'b1;
        pend_n_q   <= 2'd2;
        pend_val_q <= wdata[CNT_W-1:0];
      end else if (tick && pend_v_q) begin
        if (pend_n_q == 2'd1) pend_v_q <= 1'b0;
        else                  pend_n_q <= pend_n_q - 2'd1;
      end

      mf_q  <= (ctrl_we ? (mf_q  & wdata[MF_BIT])  : mf_q)  | hit;
      ovf_q <= (ctrl_we ? (ovf_q & wdata[OVF_BIT]) : ovf_q) | wrap;

      if (ctrl_we) begin
        ctrl_q.periodic <= wdata[PER_BIT];
        ctrl_q.ie       <= wdata[IE_BIT];
        ctrl_q.req      <= wdata[REQ_LSB+1:REQ_LSB];
        ctrl_q.cks      <= wdata[CKS_LSB+2:CKS_LSB];
      end
      if (cmp_we) cmp_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    ctrl_rd                        = '0;
    ctrl_rd[MF_BIT]                = mf_q;
    ctrl_rd[OVF_BIT]               = ovf_q;
    ctrl_rd[PER_BIT]               = ctrl_q.periodic;
    ctrl_rd[IE_BIT]                = ctrl_q.ie;
    ctrl_rd[REQ_LSB+1:REQ_LSB]     = ctrl_q.req;
    ctrl_rd[CKS_LSB+2:CKS_LSB]     = ctrl_q.cks;
  end

  assign cnt_rd = cnt_q;
  assign cmp_rd = cmp_q;
  assign tick_o = tick;
  assign irq_o  = mf_q && ctrl_q.ie && (ctrl_q.req == REQ_IRQ);
endmodule

// File: rtl/cm_timer.sv
module cm_timer
  import cm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic                         is_run;
  logic [NUM_CH-1:0]            ch_hit;
  word_e                        word;
  logic                         wr;
  logic [NUM_CH-1:0]            run_q;
  logic [NUM_CH-1:0]            ctrl_we, cnt_we, cmp_we, ch_tick;
  logic [NUM_CH-1:0][BUS_W-1:0] ch_ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_cmp;

  cm_timer_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .is_run (is_run),
    .ch_hit (ch_hit),
    .word   (word)
  );

  assign wr = bus_valid && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n)            run_q <= '0;
    else if (wr && is_run) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ctrl_we[i] = wr && ch_hit[i] && (word == W_CTRL);
    assign cnt_we[i]  = wr && ch_hit[i] && (word == W_CNT);
    assign cmp_we[i]  = wr && ch_hit[i] && (word == W_CMP);

    cm_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q[i]),
      .slow_tick (slow_tick),
      .ctrl_we   (ctrl_we[i]),
      .cnt_we    (cnt_we[i]),
      .cmp_we    (cmp_we[i]),
      .wdata     (bus_wdata),
      .ctrl_rd   (ch_ctrl[i]),
      .cnt_rd    (ch_cnt[i]),
      .cmp_rd    (ch_cmp[i]),
      .tick_o    (ch_tick[i]),
      .irq_o     (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (is_run) bus_rdata = BUS_W'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (word)
          W_CTRL:  bus_rdata = ch_ctrl[i];
          W_CNT:   bus_rdata = BUS_W'(ch_cnt[i]);
          W_CMP:   bus_rdata = BUS_W'(ch_cmp[i]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cm_timer_chk.sv
module cm_timer_chk
  import cm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0]            ch_tick,
  input logic [NUM_CH-1:0]            ctrl_we,
  input logic [BUS_W-1:0]             wdata,
  input logic [NUM_CH-1:0][BUS_W-1:0] ch_ctrl,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp,
  input logic [NUM_CH-1:0]            irq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[i] |=> $stable(ch_cnt[i]));
    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_tick[i] |=> $stable(ch_cnt[i]));
    // R7
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ctrl[i][MF_BIT]) |-> ch_cnt[i] == $past(ch_cmp[i]));
    // R6
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ctrl[i][OVF_BIT]) |-> (ch_cnt[i] == '0) && (&$past(ch_cnt[i])));
    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_ctrl[i][MF_BIT]) |-> $past(ctrl_we[i] && !wdata[MF_BIT]));
    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ch_ctrl[i][MF_BIT] && ch_ctrl[i][IE_BIT] &&
                 (ch_ctrl[i][REQ_LSB+1:REQ_LSB] == REQ_IRQ));
  end
endmodule

bind cm_timer cm_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .ch_tick (ch_tick),
  .ctrl_we (ctrl_we),
  .wdata   (bus_wdata),
  .ch_ctrl (ch_ctrl),
  .ch_cnt  (ch_cnt),
  .ch_cmp  (ch_cmp),
  .irq     (irq)
);

// File: tb/cm_timer_tb.sv
module cm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  int gap = 1;
  int tcnt = 0;
  bit done = 0;

  cm_timer #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit [NCH-1:0] m_start;
  logic [31:0]  m_cnt[NCH], m_cmp[NCH], m_pval[NCH];
  int           m_pre[NCH], m_pn[NCH], m_req[NCH], m_cks[NCH];
  bit           m_pv[NCH], m_mf[NCH], m_of[NCH], m_per[NCH], m_ie[NCH];

  function automatic logic [31:0] m_ctrl(int c);
    logic [31:0] v = '0;
    v[15] = m_mf[c]; v[14] = m_of[c]; v[8] = m_per[c]; v[7] = m_ie[c];
    v[5:4] = 2'(m_req[c]); v[2:0] = 3'(m_cks[c]);
    return v;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int c, w;
    if (a[1:0] != 0) return 0;
    if (a == 0) return 32'(m_start);
    c = int'(a >> 4) - 1;
    w = int'(a[3:2]);
    if (c < 0 || c >= NCH) return 0;
    case (w)
      0: return m_ctrl(c);
      1: return m_cnt[c];
      2: return m_cmp[c];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = '0;
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_cmp[c] = '1; m_pval[c] = 0; m_pre[c] = 0; m_pn[c] = 0;
        m_req[c] = 0; m_cks[c] = 0; m_pv[c] = 0; m_mf[c] = 0; m_of[c] = 0;
        m_per[c] = 0; m_ie[c] = 0;
      end
    end else begin
      bit wr;
      bit [NCH-1:0] old_start;
      wr = bus_valid && bus_write;
      old_start = m_start;
      for (int c = 0; c < NCH; c++) begin
        bit run, tk, hitc, wc, wn, wm, ld, setm, seto;
        int lim;
        logic [31:0] nx;
        run = old_start[c];
        hitc = wr && bus_addr[1:0] == 0 && int'(bus_addr >> 4) == c + 1;
        wc = hitc && bus_addr[3:2] == 0;
        wn = hitc && bus_addr[3:2] == 1;
        wm = hitc && bus_addr[3:2] == 2;
        case (m_cks[c]) 4: lim = 8; 5: lim = 32; 6: lim = 128; 7: lim = 1; default: lim = 0; endcase
        tk = run && slow_tick && lim != 0 && (lim == 1 || m_pre[c] == lim - 1);
        if (!run || lim <= 1) m_pre[c] = 0;
        else if (slow_tick) m_pre[c] = (m_pre[c] == lim - 1) ? 0 : (m_pre[c] + 1) % 128;
        setm = 0; seto = 0;
        ld = tk && m_pv[c] && m_pn[c] == 1 && !wn;
        if (ld) m_cnt[c] = m_pval[c];
        else if (tk) begin
          if (m_per[c]) nx = (m_cnt[c] == m_cmp[c]) ? 0 : m_cnt[c] + 1;
          else begin nx = m_cnt[c] + 1; seto = (m_cnt[c] == 32'hFFFF_FFFF); end
          setm = (nx == m_cmp[c]);
          m_cnt[c] = nx;
        end
        if (wn) begin m_pv[c] = 1; m_pn[c] = 2; m_pval[c] = bus_wdata; end
        else if (tk && m_pv[c]) begin
          if (m_pn[c] == 1) m_pv[c] = 0; else m_pn[c]--;
        end
        m_mf[c] = (wc ? (m_mf[c] & bus_wdata[15]) : m_mf[c]) | setm;
        m_of[c] = (wc ? (m_of[c] & bus_wdata[14]) : m_of[c]) | seto;
        if (wc) begin
          m_per[c] = bus_wdata[8]; m_ie[c] = bus_wdata[7];
          m_req[c] = int'(bus_wdata[5:4]); m_cks[c] = int'(bus_wdata[2:0]);
        end
        if (wm) m_cmp[c] = bus_wdata;
      end
      if (wr && bus_addr == 0) m_start = bus_wdata[NCH-1:0];
    end
  end

  // slow time base
  always @(negedge clk) begin
    tcnt++;
    slow_tick <= (tcnt % gap) == 0;
  end

  // R9: irq compared with the model on every clock
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        bit exp_irq;
        exp_irq = m_mf[c] && m_ie[c] && m_req[c] == 2;
        checks++;
        if (irq[c] !== exp_irq) begin
          errors++;
          $display("FAIL R9 ch%0d irq actual %b expected %b", c, irq[c], exp_irq);
        end
      end
    end
  end

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_model(input logic [AW-1:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a;
    #1;
    e = m_read(a);
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic rd_lit(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %h actual %h expected %h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0, a1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_lit(8'h00, 32'h0, "R1 run");
    rd_lit(8'h10, 32'h0, "R1 ctrl");
    rd_lit(8'h14, 32'h0, "R1 cnt");
    rd_lit(8'h18, 32'hFFFF_FFFF, "R1 cmp");
    rd_lit(8'h48, 32'hFFFF_FFFF, "R1 cmp ch3");

    // R11 control readback
    wr_reg(8'h20, 32'hFFFF_3FFF);
    rd_lit(8'h20, 32'h0000_01B7, "R11 ctrl bits");
    wr_reg(8'h20, 32'h0);

    // R3 unmapped offsets
    wr_reg(8'h1C, 32'h1234_5678);
    wr_reg(8'h50, 32'h0000_01A7);
    wr_reg(8'h11, 32'h0000_01A7);
    rd_lit(8'h1C, 32'h0, "R3 word3");
    rd_lit(8'h50, 32'h0, "R3 past last ch");
    rd_lit(8'h04, 32'h0, "R3 gap");
    rd_lit(8'h10, 32'h0, "R3 misaligned write ignored");

    // R5 R7 R9 periodic channel 0, bypass prescaler, pulse every cycle
    wr_reg(8'h18, 32'd4);
    wr_reg(8'h10, 32'h0000_01A7);
    wr_reg(8'h00, 32'h1);
    for (int k = 0; k < 12; k++) rd_model(8'h14, "R5 periodic count");
    rd_model(8'h10, "R7 match flag");
    // R8 clear match, keep overflow bit written as 1
    wr_reg(8'h10, 32'h0000_41A7);
    rd_model(8'h10, "R8 cleared");
    idle(3);
    // R8 writing one keeps flag
    wr_reg(8'h10, 32'h0000_81A7);
    rd_model(8'h10, "R8 kept");
    // R9 request 01 and 00 give no irq
    wr_reg(8'h10, 32'h0000_0197);
    idle(10);
    rd_model(8'h10, "R9 dma code");
    checks++;
    if (irq[0] !== 1'b0) begin errors++; $display("FAIL R9 code01 actual %b expected 0", irq[0]); end
    wr_reg(8'h10, 32'h0000_0187);
    idle(10);
    checks++;
    if (irq[0] !== 1'b0) begin errors++; $display("FAIL R9 code00 actual %b expected 0", irq[0]); end

    // R2 freeze
    wr_reg(8'h00, 32'h0);
    rd_model(8'h14, "R2 frozen a");
    a0 = bus_rdata;
    idle(20);
    rd_model(8'h14, "R2 frozen b");
    a1 = bus_rdata;
    checks++;
    if (a0 !== a1) begin errors++; $display("FAIL R2 count moved actual %h expected %h", a1, a0); end

    // R6 R10 channel 1 free-run near all ones
    wr_reg(8'h28, 32'd2);
    wr_reg(8'h20, 32'h0000_00A7);
    wr_reg(8'h00, 32'h2);
    idle(3);
    wr_reg(8'h24, 32'hFFFF_FFF0);
    rd_model(8'h24, "R10 old value");
    for (int k = 0; k < 30; k++) rd_model(8'h24, "R6 free run");
    rd_model(8'h20, "R6 overflow and match");

    // R10 two-tick delay on slow prescaler
    gap = 3;
    wr_reg(8'h20, 32'h0000_00A4);
    wr_reg(8'h24, 32'h0000_1000);
    for (int k = 0; k < 60; k++) rd_model(8'h24, "R10 delayed load");

    // R4 prescaler codes across channels
    wr_reg(8'h30, 32'h0000_0005);
    wr_reg(8'h40, 32'h0000_0006);
    wr_reg(8'h10, 32'h0000_0002);
    wr_reg(8'h00, 32'hF);
    for (int k = 0; k < 400; k++) begin
      rd_model(8'h34, "R4 div32");
      rd_model(8'h44, "R4 div128");
      rd_model(8'h14, "R4 code2 idle");
      rd_model(8'h24, "R4 div8");
    end
    rd_model(8'h00, "R2 run readback");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule